// File: doc/BRIEF.md
# PCI Function Configuration Status Register

This block holds the 16-bit status half of a PCI function's command/status configuration dword. It also holds the three command bits that the status logic depends on: parity-error response, system-error enable and interrupt disable. The bus master and target engines report events as single-cycle strobes. The block latches qualifying events as sticky flags, and software clears each flag by writing a one to it. The block returns fixed capability bits and reports whether an enabled interrupt is pending. It drives the function's active-low legacy interrupt pin from a registered copy of the gated request.

Configuration access works on whole dwords. `cfg_addr` is the dword index, so index 1 covers byte offsets 04h to 07h. The command register sits in the low half of that dword and the status register in the high half, at byte offset 06h. Each write is qualified per byte by `cfg_be`. A read returns the whole dword one clock after `cfg_rd`.

Top module: `cfg_status_reg`

## Requirements
- R1: After reset, dword 1 reads 0210_0000h: status is 0210h, all command bits are 0, and `intx_n` is 1.
- R2: Status bits 10:9 always read 01b and bit 4 always reads 1. Bits 7, 6, 5 and 2:0 always read 0. No write changes any of these bits.
- R3: Status bits 15, 14, 13, 12, 11 and 8 are sticky. A write to dword 1 with `cfg_be[3]`=1 clears each of these bits whose write-data bit (16 + bit) is 1. A 0 data bit leaves the flag unchanged. A write with `cfg_be[3]`=0, or a write to any other dword, leaves every flag unchanged.
- R4: Status bit 15 sets on an address-parity or a data-parity strobe, whether or not this function is bus master.
- R5: Status bit 14 sets on a system-error strobe only while command bit 8 (system-error enable) is 1.
- R6: Status bit 13 sets on a master-abort strobe. Bit 12 sets on a received-target-abort strobe. Bit 11 sets on a signaled-target-abort strobe.
- R7: Status bit 8 sets only when three conditions hold in the same cycle: `perr_seen`=1, `bus_master`=1 and command bit 6 (parity response) is 1.
- R8: If a set event and a write-1 clear reach the same sticky bit in the same cycle, the bit ends up set.
- R9: Status bit 3 becomes `irq_pending & irq_enable` one clock after those inputs change. Command bit 10 has no effect on it.
- R10: `intx_n` is 0 exactly when, one clock earlier, status bit 3 was 1 and command bit 10 was 0. Otherwise `intx_n` is 1.
- R11: A write to dword 1 sets command bit 6 from data bit 6 under `cfg_be[0]`, and command bits 8 and 10 from data bits 8 and 10 under `cfg_be[1]`. All other command bits read 0.
- R12: `cfg_rdata` loads on the clock edge where `cfg_rd` is 1. A read of any dword other than 1 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | ADDR_W | Dword index of the access |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| ev_addr_perr | input | 1 | Address parity error detected |
| ev_data_perr | input | 1 | Data parity error detected |
| ev_serr | input | 1 | Function signaled a system error |
| ev_mabort | input | 1 | Own cycle ended in master abort |
| ev_tabort_rcv | input | 1 | Own cycle ended in target abort |
| ev_tabort_sig | input | 1 | Function terminated a cycle with target abort |
| perr_seen | input | 1 | Parity error signal asserted by any agent |
| bus_master | input | 1 | Function was master for the data phase |
| irq_pending | input | 1 | Interrupt condition present |
| irq_enable | input | 1 | Signaling of that condition is enabled |
| intx_n | output | 1 | Active-low legacy interrupt request |

## Verification
The bench builds the block with its default parameters: a 6-bit dword index with the register pair at index 1. With these values, accesses to the register dword can be mixed with accesses to other dwords, so misdirected writes and reads are in reach. The vector table runs each event strobe both with and without its qualifying enable. The directed tests cover the following: set and clear colliding in one cycle, clears gated by the byte enables, the two-stage interrupt path checked cycle by cycle, and the disable bit leaving status bit 3 untouched.

// File: rtl/cfg_stat_pkg.sv
package cfg_stat_pkg;

  localparam int NFLAG = 6;

  // sticky flag indices
  localparam int F_DPAR = 0;
  localparam int F_TSIG = 1;
  localparam int F_TREC = 2;
  localparam int F_MABT = 3;
  localparam int F_SERR = 4;
  localparam int F_PERR = 5;

  localparam logic [15:0] STAT_FIXED = 16'h0210;

  localparam int CMD_PERR_EN = 6;
  localparam int CMD_SERR_EN = 8;
  localparam int CMD_INT_DIS = 10;
  localparam int STAT_INT    = 3;

  typedef struct packed {
    logic perr_en;
    logic serr_en;
    logic int_dis;
  } cmd_t;

  function automatic int flag_pos(input int idx);
    case (idx)
      F_DPAR:  return 8;
      F_TSIG:  return 11;
      F_TREC:  return 12;
      F_MABT:  return 13;
      F_SERR:  return 14;
      default: return 15;
    endcase
  endfunction

endpackage

// File: rtl/cfg_sticky_bank.sv
module cfg_sticky_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_q
);

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           flag_q[g] <= 1'b0;
      else if (set_i[g]) flag_q[g] <= 1'b1;  // set beats clear
      else if (clr_i[g]) flag_q[g] <= 1'b0;
    end
  end

endmodule

// File: rtl/cfg_cmd_slice.sv
module cfg_cmd_slice
  import cfg_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_i,
  input  logic [1:0] be_i,
  input  logic       perr_en_d,
  input  logic       serr_en_d,
  input  logic       int_dis_d,
  output cmd_t       cmd_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
    end else if (wr_i) begin
      if (be_i[0]) cmd_q.perr_en <= perr_en_d;
      if (be_i[1]) begin
        cmd_q.serr_en <= serr_en_d;
        cmd_q.int_dis <= int_dis_d;
      end
    end
  end

endmodule

// File: rtl/cfg_irq_gate.sv
module cfg_irq_gate (
  input  logic clk,
  input  logic rst,
  input  logic pending_i,
  input  logic enable_i,
  input  logic int_dis_i,
  output logic stat_int_q,
  output logic intx_n_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_int_q <= 1'b0;
      intx_n_q   <= 1'b1;
    end else begin
      stat_int_q <= pending_i & enable_i;
      intx_n_q   <= ~(stat_int_q & ~int_dis_i);
    end
  end

endmodule

// File: rtl/cfg_status_reg.sv
module cfg_status_reg
  import cfg_stat_pkg::*;
#(
  parameter int              ADDR_W = 6,
  parameter logic [ADDR_W-1:0] CMD_DW = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              ev_addr_perr,
  input  logic              ev_data_perr,
  input  logic              ev_serr,
  input  logic              ev_mabort,
  input  logic              ev_tabort_rcv,
  input  logic              ev_tabort_sig,
  input  logic              perr_seen,
  input  logic              bus_master,
  input  logic              irq_pending,
  input  logic              irq_enable,
  output logic              intx_n
);

  localparam int STAT_LSB = 16;

  logic             hit;
  logic             reg_wr;
  cmd_t             cmd_q;
  logic [NFLAG-1:0] flag_set;
  logic [NFLAG-1:0] flag_clr;
  logic [NFLAG-1:0] flag_q;
  logic             stat_int_q;
  logic [15:0]      status_w;
  logic [15:0]      cmd_w;

  assign hit    = (cfg_addr == CMD_DW);
  assign reg_wr = cfg_wr & hit;

  cfg_cmd_slice u_cmd (
    .clk       (clk),
    .rst       (rst),
    .wr_i      (reg_wr),
    .be_i      (cfg_be[1:0]),
    .perr_en_d (cfg_wdata[CMD_PERR_EN]),
    .serr_en_d (cfg_wdata[CMD_SERR_EN]),
    .int_dis_d (cfg_wdata[CMD_INT_DIS]),
    .cmd_q     (cmd_q)
  );

  // qualified set conditions
  always_comb begin
    flag_set         = '0;
    flag_set[F_PERR] = ev_addr_perr | ev_data_perr;
    flag_set[F_SERR] = ev_serr & cmd_q.serr_en;
    flag_set[F_MABT] = ev_mabort;
    flag_set[F_TREC] = ev_tabort_rcv;
    flag_set[F_TSIG] = ev_tabort_sig;
    flag_set[F_DPAR] = perr_seen & bus_master & cmd_q.perr_en;
  end

  // write-one clears, each qualified by its own byte lane
  for (genvar g = 0; g < NFLAG; g++) begin : g_clr
    localparam int BITN = STAT_LSB + flag_pos(g);
    assign flag_clr[g] = reg_wr & cfg_be[BITN/8] & cfg_wdata[BITN];
  end

  cfg_sticky_bank #(.N(NFLAG)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .flag_q (flag_q)
  );

  cfg_irq_gate u_irq (
    .clk        (clk),
    .rst        (rst),
    .pending_i  (irq_pending),
    .enable_i   (irq_enable),
    .int_dis_i  (cmd_q.int_dis),
    .stat_int_q (stat_int_q),
    .intx_n_q   (intx_n)
  );

  always_comb begin
    status_w           = STAT_FIXED;
    status_w[STAT_INT] = stat_int_q;
    for (int i = 0; i < NFLAG; i++) status_w[flag_pos(i)] = flag_q[i];
  end

  always_comb begin
    cmd_w              = '0;
    cmd_w[CMD_PERR_EN] = cmd_q.perr_en;
    cmd_w[CMD_SERR_EN] = cmd_q.serr_en;
    cmd_w[CMD_INT_DIS] = cmd_q.int_dis;
  end

  always_ff @(posedge clk) begin
    if (rst)         cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= hit ? {status_w, cmd_w} : 32'h0;
  end

endmodule

// File: rtl/cfg_status_reg_chk.sv
module cfg_status_reg_chk #(
  parameter int                ADDR_W = 6,
  parameter logic [ADDR_W-1:0] CMD_DW = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [3:0]        cfg_be,
  input logic [31:0]       cfg_wdata,
  input logic              ev_addr_perr,
  input logic              ev_data_perr,
  input logic              ev_mabort,
  input logic              perr_seen,
  input logic              bus_master,
  input logic [15:0]       status,
  input logic              perr_en,
  input logic              int_dis,
  input logic              intx_n
);

  logic clr15;
  assign clr15 = cfg_wr && (cfg_addr == CMD_DW) && cfg_be[3] && cfg_wdata[31];

  // R1
  reset_value_chk: assert property (@(posedge clk) rst |=> (status == 16'h0210 && intx_n));

  // R2
  fixed_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (status[10:9] == 2'b01 && status[4] && status[7:5] == 3'b000 && status[2:0] == 3'b000));

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (status[15] && !clr15) |=> status[15]);

  // R4
  parity_set_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_addr_perr || ev_data_perr) |=> status[15]);

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ev_mabort |=> status[13]);

  // R7
  dpar_qual_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status[8]) |-> $past(perr_seen && bus_master && perr_en));

  // R10
  intx_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !intx_n |-> ($past(status[3]) && !$past(int_dis)));

endmodule

bind cfg_status_reg cfg_status_reg_chk #(.ADDR_W(ADDR_W), .CMD_DW(CMD_DW)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .cfg_wr       (cfg_wr),
  .cfg_addr     (cfg_addr),
  .cfg_be       (cfg_be),
  .cfg_wdata    (cfg_wdata),
  .ev_addr_perr (ev_addr_perr),
  .ev_data_perr (ev_data_perr),
  .ev_mabort    (ev_mabort),
  .perr_seen    (perr_seen),
  .bus_master   (bus_master),
  .status       (status_w),
  .perr_en      (cmd_q.perr_en),
  .int_dis      (cmd_q.int_dis),
  .intx_n       (intx_n)
);

// File: tb/cfg_status_reg_tb_top.sv
module cfg_status_reg_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] REG_DW = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 0, cfg_rd = 0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [3:0] cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic ev_addr_perr = 0, ev_data_perr = 0, ev_serr = 0, ev_mabort = 0;
  logic ev_tabort_rcv = 0, ev_tabort_sig = 0, perr_seen = 0, bus_master = 0;
  logic irq_pending = 0, irq_enable = 0;
  logic intx_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_status_reg #(.ADDR_W(ADDR_W), .CMD_DW(REG_DW)) dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ev_addr_perr(ev_addr_perr), .ev_data_perr(ev_data_perr), .ev_serr(ev_serr),
    .ev_mabort(ev_mabort), .ev_tabort_rcv(ev_tabort_rcv), .ev_tabort_sig(ev_tabort_sig),
    .perr_seen(perr_seen), .bus_master(bus_master), .irq_pending(irq_pending),
    .irq_enable(irq_enable), .intx_n(intx_n)
  );

  // {command value, event bits, expected status}
  // event bits: 0 addr_perr, 1 data_perr, 2 serr, 3 mabort, 4 tabort_rcv,
  //             5 tabort_sig, 6 perr_seen, 7 bus_master
  localparam int NVEC = 12;
  localparam logic [39:0] VEC [NVEC] = '{
    {16'h0000, 8'h01, 16'h8210},  // R4 address parity
    {16'h0000, 8'h02, 16'h8210},  // R4 data parity, not master
    {16'h0000, 8'h04, 16'h0210},  // R5 system error disabled
    {16'h0100, 8'h04, 16'h4210},  // R5 system error enabled
    {16'h0000, 8'h08, 16'h2210},  // R6 master abort
    {16'h0000, 8'h10, 16'h1210},  // R6 target abort received
    {16'h0000, 8'h20, 16'h0A10},  // R6 target abort signaled
    {16'h0040, 8'hC0, 16'h0310},  // R7 all three conditions
    {16'h0040, 8'h40, 16'h0210},  // R7 not master
    {16'h0000, 8'hC0, 16'h0210},  // R7 response disabled
    {16'h0040, 8'h80, 16'h0210},  // R7 no parity signal
    {16'h0140, 8'hFF, 16'hFB10}   // R4 R5 R6 R7 all at once
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [ADDR_W-1:0] a, input logic [3:0] be, input logic [31:0] d);
    cfg_wr = 1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0; cfg_be = '0; cfg_wdata = '0;
  endtask

  task automatic cfg_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    cfg_rd = 1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 0;
    d = cfg_rdata;
  endtask

  task automatic set_events(input logic [7:0] ev);
    {bus_master, perr_seen, ev_tabort_sig, ev_tabort_rcv, ev_mabort,
     ev_serr, ev_data_perr, ev_addr_perr} = ev;
  endtask

  task automatic pulse(input logic [7:0] ev);
    set_events(ev);
    @(negedge clk);
    set_events(8'h00);
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    check("R1 intx_n", {31'h0, intx_n}, 32'h1);
    cfg_read(REG_DW, rd);
    check("R1 dword", rd, 32'h0210_0000);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      cfg_write(REG_DW, 4'b1100, 32'hFFFF_0000);
      cfg_write(REG_DW, 4'b0011, {16'h0, VEC[i][39:24]});
      pulse(VEC[i][23:16]);
      cfg_read(REG_DW, rd);
      check($sformatf("R4-7 vector %0d", i), {16'h0, rd[31:16]}, {16'h0, VEC[i][15:0]});
    end

    // R3 clear gating; all flags currently set from last vector
    cfg_write(REG_DW, 4'b1000, 32'h8000_0000);
    cfg_read(REG_DW, rd);
    check("R3 clear bit 15 only", {16'h0, rd[31:16]}, 32'h7B10);
    cfg_write(REG_DW, 4'b0100, 32'hFFFF_0000);
    cfg_read(REG_DW, rd);
    check("R3 lane 3 disabled", {16'h0, rd[31:16]}, 32'h7B10);
    cfg_write(REG_DW, 4'b1000, 32'h0000_0000);
    cfg_write(6'd0, 4'b1111, 32'hFFFF_FFFF);
    cfg_read(REG_DW, rd);
    check("R3 zero data / other dword", {16'h0, rd[31:16]}, 32'h7B10);
    cfg_write(REG_DW, 4'b1000, 32'hFFFF_0000);
    cfg_read(REG_DW, rd);
    check("R3 clear all", {16'h0, rd[31:16]}, 32'h0210);

    // R2 fixed bits against writes of ones and zeros
    cfg_write(REG_DW, 4'b1100, 32'hFFFF_0000);
    cfg_write(REG_DW, 4'b1100, 32'h0000_0000);
    cfg_read(REG_DW, rd);
    check("R2 fixed bits", {16'h0, rd[31:16]}, 32'h0210);

    // R8 set and clear in the same cycle
    cfg_write(REG_DW, 4'b0011, 32'h0);
    pulse(8'h18);
    set_events(8'h08);
    cfg_write(REG_DW, 4'b1000, 32'h3000_0000);
    set_events(8'h00);
    cfg_read(REG_DW, rd);
    check("R8 set wins", {16'h0, rd[31:16]}, 32'h2210);
    cfg_write(REG_DW, 4'b1000, 32'hFF00_0000);

    // R11 command bits
    cfg_write(REG_DW, 4'b0011, 32'h0000_FFFF);
    cfg_read(REG_DW, rd);
    check("R11 command all ones", {16'h0, rd[15:0]}, 32'h0540);
    cfg_write(REG_DW, 4'b0001, 32'h0000_0000);
    cfg_read(REG_DW, rd);
    check("R11 lane 0 only", {16'h0, rd[15:0]}, 32'h0500);
    cfg_write(REG_DW, 4'b0011, 32'h0000_0000);

    // R12 other dword reads zero
    cfg_read(6'd5, rd);
    check("R12 other dword", rd, 32'h0);

    // R9 / R10 interrupt path
    irq_pending = 1; irq_enable = 0;
    repeat (3) @(negedge clk);
    cfg_read(REG_DW, rd);
    check("R9 not enabled", {31'h0, rd[19]}, 32'h0);
    check("R10 no request", {31'h0, intx_n}, 32'h1);
    irq_enable = 1;
    @(negedge clk);
    check("R10 one cycle after status", {31'h0, intx_n}, 32'h1);
    @(negedge clk);
    check("R10 asserted", {31'h0, intx_n}, 32'h0);
    cfg_write(REG_DW, 4'b0010, 32'h0000_0400);
    check("R10 disable latency", {31'h0, intx_n}, 32'h0);
    @(negedge clk);
    check("R10 disabled", {31'h0, intx_n}, 32'h1);
    cfg_read(REG_DW, rd);
    check("R9 status kept while disabled", {31'h0, rd[19]}, 32'h1);
    cfg_write(REG_DW, 4'b0010, 32'h0000_0000);
    @(negedge clk);
    check("R10 reenabled", {31'h0, intx_n}, 32'h0);
    irq_pending = 0;
    repeat (2) @(negedge clk);
    cfg_read(REG_DW, rd);
    check("R9 cleared", {31'h0, rd[19]}, 32'h0);
    check("R10 released", {31'h0, intx_n}, 32'h1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule